// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One down-counter channel of a programmable interval timer. It advances on a single-cycle count-enable tick, and only while its gate input is high. It drives one output pin that produces either a periodic low pulse or a square wave. A register interface supplies three things: a mode code written with a control strobe, a reload value, and a strobe that marks the reload value as complete. The live count is always visible at a port, so a host can snapshot it.

Counting is held off until a complete reload value has been delivered. Any control write clears that condition again and parks the channel with its output high. Mode codes other than the two periodic ones leave the channel idle.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is high and the count is 0. No tick changes either of them until a reload value has been loaded.
- R2: The count and the output change on a tick only while the gate input is high. With the gate low, or with no tick, both hold their values.
- R3: A load strobe stores the reload value, marks the channel loaded and restarts it. In mode 2 the count becomes the reload value. In mode 3 the count becomes the length of the high half. A load strobe given before any control write still captures its value.
- R4: Mode code 2 (pulse): starting from N, the count steps down N, N-1, ... , 1 and then returns to N. The output is low exactly while the count equals 1, which gives one low tick per N ticks.
- R5: Mode code 3 (square): the high half lasts ceil(N/2) ticks and the low half floor(N/2) ticks, with a minimum of one tick. The count shows the ticks left in the current half. The output toggles when the count reaches 1 and a tick arrives.
- R6: A reload value of 0 acts as 65536. In mode 2 the count wraps to 0xFFFF on the first tick. In mode 3 each half is 32768 ticks.
- R7: A control write stores the 3-bit mode code, clears the loaded state and forces the output high. The count holds its value. A load strobe in the same cycle as a control write is ignored.
- R8: Under any mode code other than 2 or 3, the channel does not count and its output stays high, even when it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable tick, one cycle wide |
| gate | input | 1 | Counting permitted while high |
| ctrl_wr | input | 1 | Control write strobe |
| mode_in | input | 3 | Mode code captured by ctrl_wr |
| load_stb | input | 1 | Reload value complete strobe |
| reload_in | input | 16 | Reload value captured by load_stb |
| count_o | output | 16 | Live count |
| out_o | output | 1 | Channel output pin |

## Verification
Every register in this channel reaches the ports within one clock. A wrong count shows on count_o at the next tick. A stale output level, or a mistaken half length, shows at the first terminal count, which comes after no more than N enabled ticks. A loaded flag that fails to clear, or an ignored gate, moves count_o on a tick where it should have held, so the error appears in the very next cycle. Sweeping small reload values in both periodic modes, with irregular ticks and gate dropouts, brings every terminal-count transition to the ports many times.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;
  localparam int unsigned MODE_W      = 3;
  localparam logic [MODE_W-1:0] MODE_PULSE  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_SQUARE = 3'd3;
  // Selector for the half-length calculator
  localparam bit HALF_HIGH = 1'b0;
  localparam bit HALF_LOW  = 1'b1;
endpackage

// File: rtl/pit_half_len.sv
// Length of one half of a square-wave period; a zero value means 2**W.
module pit_half_len #(
  parameter int unsigned W   = 16,
  parameter bit          SEL = 1'b0
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] len_o
);
  localparam logic [W:0]   FULL_EXT = {1'b1, {W{1'b0}}};
  localparam logic [W:0]   ONE_EXT  = {{W{1'b0}}, 1'b1};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  logic [W:0] n_ext;
  logic [W:0] half_ext;

  assign n_ext = (val_i == '0) ? FULL_EXT : {1'b0, val_i};

  generate
    if (SEL == 1'b0) begin : g_high
      assign half_ext = (n_ext + ONE_EXT) >> 1;
    end else begin : g_low
      assign half_ext = n_ext >> 1;
    end
  endgenerate

  assign len_o = (half_ext == '0) ? ONE : half_ext[W-1:0];
endmodule

// File: rtl/pit_cfg_regs.sv
module pit_cfg_regs
  import pit_chan_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              load_stb,
  input  logic [W-1:0]      reload_in,
  output logic              load_acc,
  output logic [MODE_W-1:0] mode_q,
  output logic [W-1:0]      reload_q,
  output logic              loaded_q
);
  logic [MODE_W-1:0] mode_n;
  logic [W-1:0]      reload_n;
  logic              loaded_n;

  assign load_acc = load_stb & ~ctrl_wr;

  always_comb begin
    mode_n   = mode_q;
    reload_n = reload_q;
    loaded_n = loaded_q;
    if (ctrl_wr) begin
      mode_n   = mode_in;
      loaded_n = 1'b0;
    end else if (load_acc) begin
      reload_n = reload_in;
      loaded_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      reload_q <= '0;
      loaded_q <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      reload_q <= reload_n;
      loaded_q <= loaded_n;
    end
  end

  assert_ctrl_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !loaded_q && (mode_q == $past(mode_in)));
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_chan_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              gate,
  input  logic              ctrl_wr,
  input  logic              load_acc,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              loaded_q,
  input  logic [W-1:0]      reload_in,
  input  logic [W-1:0]      reload_q,
  input  logic [W-1:0]      in_hi_len,
  input  logic [W-1:0]      q_hi_len,
  input  logic [W-1:0]      q_lo_len,
  output logic [W-1:0]      count_q,
  output logic              out_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic          mode_ok;
  logic          step_en;
  logic          at_term;
  logic [W-1:0]  count_n;
  logic          out_n;

  assign mode_ok = (mode_q == MODE_PULSE) || (mode_q == MODE_SQUARE);
  assign step_en = tick_en & gate & loaded_q & mode_ok;
  assign at_term = (count_q == ONE);

  always_comb begin
    count_n = count_q;
    out_n   = out_q;
    if (ctrl_wr) begin
      out_n = 1'b1;
    end else if (load_acc) begin
      if (mode_q == MODE_SQUARE) begin
        count_n = in_hi_len;
        out_n   = 1'b1;
      end else if (mode_q == MODE_PULSE) begin
        count_n = reload_in;
        out_n   = (reload_in != ONE);
      end else begin
        count_n = reload_in;
        out_n   = 1'b1;
      end
    end else if (step_en) begin
      count_n = at_term ? reload_q : (count_q - ONE);
      if (mode_q == MODE_SQUARE) begin
        if (at_term) begin
          out_n   = ~out_q;
          count_n = out_q ? q_lo_len : q_hi_len;
        end
      end else begin
        out_n = (count_n != ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      out_q   <= 1'b1;
    end else begin
      count_q <= count_n;
      out_q   <= out_n;
    end
  end

  assert_gate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_en && gate) && !ctrl_wr && !load_acc) |=> $stable(count_q) && $stable(out_q));

  assert_pulse_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PULSE && loaded_q && tick_en && gate && count_q == ONE
     && !ctrl_wr && !load_acc) |=> count_q == reload_q);

  assert_square_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SQUARE && loaded_q && tick_en && gate && count_q == ONE
     && !ctrl_wr && !load_acc) |=> out_q != $past(out_q));

  assert_ctrl_out_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> out_q && $stable(count_q));

  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded_q || !mode_ok) |-> out_q);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_chan_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              gate,
  input  logic              ctrl_wr,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              load_stb,
  input  logic [W-1:0]      reload_in,
  output logic [W-1:0]      count_o,
  output logic              out_o
);
  logic              load_acc;
  logic [MODE_W-1:0] mode_q;
  logic [W-1:0]      reload_q;
  logic              loaded_q;
  logic [W-1:0]      in_hi_len;
  logic [W-1:0]      q_hi_len;
  logic [W-1:0]      q_lo_len;

  pit_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .mode_in(mode_in),
    .load_stb(load_stb), .reload_in(reload_in), .load_acc(load_acc),
    .mode_q(mode_q), .reload_q(reload_q), .loaded_q(loaded_q)
  );

  pit_half_len #(.W(W), .SEL(HALF_HIGH)) u_in_hi (.val_i(reload_in), .len_o(in_hi_len));
  pit_half_len #(.W(W), .SEL(HALF_HIGH)) u_q_hi  (.val_i(reload_q),  .len_o(q_hi_len));
  pit_half_len #(.W(W), .SEL(HALF_LOW))  u_q_lo  (.val_i(reload_q),  .len_o(q_lo_len));

  pit_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .ctrl_wr(ctrl_wr), .load_acc(load_acc), .mode_q(mode_q),
    .loaded_q(loaded_q), .reload_in(reload_in), .reload_q(reload_q),
    .in_hi_len(in_hi_len), .q_hi_len(q_hi_len), .q_lo_len(q_lo_len),
    .count_q(count_o), .out_q(out_o)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded_q && !load_stb) |=> $stable(count_o));
endmodule

// File: tb/sim_pit_channel.sv
`timescale 1ns/1ps
module sim_pit_channel;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        gate;
  logic        ctrl_wr;
  logic [2:0]  mode_in;
  logic        load_stb;
  logic [15:0] reload_in;
  logic [15:0] count_o;
  logic        out_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] lfsr = 8'hA5;

  pit_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .ctrl_wr(ctrl_wr), .mode_in(mode_in), .load_stb(load_stb),
    .reload_in(reload_in), .count_o(count_o), .out_o(out_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string req, logic [15:0] exp_cnt, logic exp_out);
    checks++;
    if (count_o !== exp_cnt || out_o !== exp_out) begin
      errors++;
      $display("FAIL %s count=%0d out=%0b expected count=%0d out=%0b",
               req, count_o, out_o, exp_cnt, exp_out);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    tick_en = 0; gate = 0; ctrl_wr = 0; load_stb = 0;
  endtask

  task automatic write_ctrl(logic [2:0] m);
    idle_inputs(); ctrl_wr = 1; mode_in = m;
    step();
    ctrl_wr = 0;
  endtask

  task automatic write_load(logic [15:0] v);
    idle_inputs(); load_stb = 1; reload_in = v;
    step();
    load_stb = 0;
  endtask

  function automatic int n_of(int v);
    return (v == 0) ? 65536 : v;
  endfunction

  // Expected after t enabled ticks since load
  function automatic logic [16:0] expect_at(int m, int v, int t);
    int n, hi, lo, p, c;
    logic o;
    n = n_of(v);
    if (m == 2) begin
      c = n - (t % n);
      o = (c != 1);
    end else begin
      hi = (n + 1) / 2;
      lo = n / 2; if (lo == 0) lo = 1;
      p = t % (hi + lo);
      if (p < hi) begin c = hi - p; o = 1; end
      else begin c = lo - (p - hi); o = 0; end
    end
    return {o, c[15:0]};
  endfunction

  task automatic run_case(int m, int v, int cycles, string req);
    int t;
    logic [16:0] e;
    write_ctrl(m[2:0]);
    write_load(v[15:0]);
    t = 0;
    e = expect_at(m, v, t);
    check(req, e[15:0], e[16]);
    for (int k = 0; k < cycles; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick_en = lfsr[0] | lfsr[1];
      gate    = (lfsr[4:2] != 3'b000);
      step();
      if (tick_en && gate) t++;
      e = expect_at(m, v, t);
      check((tick_en && gate) ? req : "R2", e[15:0], e[16]);
    end
    idle_inputs();
  endtask

  initial begin
    logic [15:0] held;
    idle_inputs(); mode_in = 0; reload_in = 0;
    rst_n = 0;
    #12;
    @(negedge clk); rst_n = 1;
    step();
    check("R1 reset", 16'd0, 1'b1);
    // R1/R3: ticking without a completed load does nothing
    write_ctrl(3'd2);
    tick_en = 1; gate = 1;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R3 no count before load", 16'd0, 1'b1);
    end
    idle_inputs();
    // R4 and R5 sweeps over small reload values
    for (int n = 1; n <= 12; n++) run_case(2, n, 6 * n + 4, "R4");
    for (int n = 1; n <= 12; n++) run_case(3, n, 6 * n + 4, "R5");
    run_case(2, 300, 700, "R4");
    run_case(3, 301, 700, "R5");
    // R6: zero reload acts as 65536
    run_case(2, 0, 40, "R6");
    run_case(3, 0, 40, "R6");
    // R7: control write mid-run halts and forces output high
    run_case(2, 7, 9, "R4");
    held = count_o;
    idle_inputs(); ctrl_wr = 1; mode_in = 3'd2; tick_en = 1; gate = 1;
    step();
    ctrl_wr = 0;
    check("R7 ctrl write holds count", held, 1'b1);
    for (int k = 0; k < 4; k++) begin
      step();
      check("R7 unloaded after ctrl", held, 1'b1);
    end
    idle_inputs();
    // R7: load in same cycle as control write is ignored
    ctrl_wr = 1; load_stb = 1; mode_in = 3'd2; reload_in = 16'd77;
    step();
    idle_inputs();
    tick_en = 1; gate = 1;
    step();
    check("R7 same-cycle load ignored", held, 1'b1);
    idle_inputs();
    // R3: a subsequent load restarts counting
    write_load(16'd5);
    check("R3 load sets count", 16'd5, 1'b1);
    tick_en = 1; gate = 1;
    step();
    check("R3 counting after load", 16'd4, 1'b1);
    idle_inputs();
    // R8: other mode codes stay idle with output high
    for (int m = 0; m < 8; m++) begin
      if (m == 2 || m == 3) continue;
      write_ctrl(m[2:0]);
      write_load(16'd9);
      tick_en = 1; gate = 1;
      for (int k = 0; k < 3; k++) begin
        step();
        check("R8 idle mode", 16'd9, 1'b1);
      end
      idle_inputs();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule